// File: doc/BRIEF.md
# Masked Byte-Pattern Packet Filter

This block watches a stream of packets arriving as 64-bit beats, each beat carrying a valid strobe, an end-of-packet marker and an eight-bit lane keep mask. It compares the leading bytes of each packet against a stored pattern of up to 128 bytes. Every pattern byte has its own enable bit, and only enabled bytes take part. A programmed window length sets how many leading bytes the packet must have. It also sets how many eight-byte groups are compared. For each packet the block produces a single pass or fail verdict.

The pattern, the byte enables and the window length are written through a separate configuration port. Configuration is laid out as rows of four 32-bit words. Each row covers eight pattern bytes. The length lives in the last word of the last row. Configuration is cleared only by the power-on reset. A separate soft reset clears only the per-packet tracking and the verdict.

Comparison works on whole eight-byte groups. Every group that holds part of the window is compared on all eight lanes. When the window length is not a multiple of eight, bytes past the window take part, including lanes of the final beat that the keep mask marks as absent. The per-packet tracker is a three-state machine. ST_IDLE waits for the first beat of a packet. ST_CMP accepts beats whose group lies inside the comparison window. ST_TAIL accepts beats past the window and only counts their bytes. The transitions are:
- IDLE_TO_CMP: a first beat that is not last, when group 1 is still inside the window.
- IDLE_TO_TAIL: a first beat that is not last, when the window covers at most one group.
- CMP_TO_TAIL: a non-last beat after which the next group falls outside the window.
- CMP_TO_IDLE and TAIL_TO_IDLE: a last beat.
- A single-beat packet leaves the machine in ST_IDLE.

Top module: `pktpat_filter`

## Requirements
- R1: After power-on reset every pattern byte, every enable bit and the window length are zero, so every packet passes until the block is configured.
- R2: A pattern byte whose enable bit is 0 never affects the verdict, whatever the packet holds at that position.
- R3: If any enabled byte inside the compared groups differs from the packet, the verdict is fail.
- R4: A packet whose byte count, taken as eight bytes per beat plus the keep-mask population of the last beat, is below the window length always fails.
- R5: A packet at least as long as the window passes when all enabled bytes in groups 0 to ceil(length/8)-1 match. Bytes in later groups are ignored. A length of 0 always passes.
- R6: For a window length that is not a multiple of eight, every lane of the final compared group is compared, including bytes past the window and lanes the keep mask marks absent on the last beat.
- R7: The verdict appears as res_valid high for exactly one cycle, the cycle after the beat with s_valid and s_last is accepted, with res_pass valid in that cycle. res_valid is low in all other cycles.
- R8: A new packet may begin on the cycle right after a last beat. Its verdict is independent of the previous packet.
- R9: A low soft reset (rst_n) discards any partial packet and clears the verdict outputs, but leaves the pattern, the enables and the length unchanged.
- R10: A length write whose value in bits 7:0 exceeds 128 is ignored. Writes to the fourth word of any row except the last change nothing. Bits 31:8 of an enable word are ignored.
- R11: Configuration address is row*4+word. Word 0 holds row bytes 0..3 and word 1 holds bytes 4..7, lowest byte in bits 7:0. Word 2 bit i enables byte i of the row. Packet byte k is lane k mod 8, bits 8*(k mod 8)+7 to 8*(k mod 8), of beat k/8.
- R12: Cycles with s_valid low are ignored entirely, including their data, keep and last values, even in the middle of a packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous; clears everything |
| rst_n | input | 1 | Soft reset, active low, synchronous; clears packet state only |
| s_valid | input | 1 | Beat present on the stream |
| s_data | input | 64 | Beat data, packet byte k in lane k mod 8 |
| s_keep | input | 8 | Lane presence mask, contiguous from lane 0 on the last beat |
| s_last | input | 1 | Final beat of the packet |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 6 | Configuration word address, row*4+word |
| cfg_wdata | input | 32 | Configuration write data |
| res_valid | output | 1 | One-cycle verdict strobe |
| res_pass | output | 1 | Verdict: 1 pass, 0 fail |

## Verification
On every cycle the assertions check several properties. The verdict strobe must follow each accepted last beat by exactly one cycle. A packet shorter than the window must never report a pass, and a zero-length window must never report a fail. The stored length must stay within 128 and must hold steady without a write, across soft resets as well. Only the bench's scenarios can show the byte-level outcomes: lane ordering, enable masking, comparison of padding lanes for unaligned lengths, and bytes past the window being ignored. The same holds for ignored configuration writes, whose effect is visible only through later verdicts against a reference model.

// File: rtl/pktpat_pkg.sv
package pktpat_pkg;

    // Byte lanes per stream beat and per configuration row.
    localparam int LANES = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMP  = 2'd1,
        ST_TAIL = 2'd2
    } flt_state_e;

    function automatic logic [3:0] lane_count(input logic [LANES-1:0] keep);
        logic [3:0] n;
        n = '0;
        for (int i = 0; i < LANES; i++) begin
            n = n + {3'b000, keep[i]};
        end
        return n;
    endfunction

endpackage

// File: rtl/pktpat_cfg_store.sv
module pktpat_cfg_store
    import pktpat_pkg::*;
#(
    parameter int ROWS    = 16,
    parameter int MAX_LEN = 128,
    parameter int LEN_W   = 8,
    parameter int CFG_AW  = 6
) (
    input  logic                          clk,
    input  logic                          por_n,
    input  logic                          we,
    input  logic [CFG_AW-1:0]             addr,
    input  logic [31:0]                   wdata,
    output logic [ROWS-1:0][LANES*8-1:0]  pat_o,
    output logic [ROWS-1:0][LANES-1:0]    mask_o,
    output logic [LEN_W-1:0]              len_o
);

    localparam int ROW_W = CFG_AW - 2;
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

    logic [ROW_W-1:0] wr_row;
    logic [1:0]       wr_word;
    logic             len_ok;

    assign wr_row  = addr[CFG_AW-1:2];
    assign wr_word = addr[1:0];
    assign len_ok  = ({1'b0, wdata[LEN_W-1:0]} <= (LEN_W+1)'(MAX_LEN));

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic hit;
        assign hit = we && (wr_row == ROW_W'(r));

        always_ff @(posedge clk) begin
            if (!por_n) begin
                pat_o[r]  <= '0;
                mask_o[r] <= '0;
            end else if (hit) begin
                unique case (wr_word)
                    2'd0:    pat_o[r][31:0]  <= wdata;
                    2'd1:    pat_o[r][63:32] <= wdata;
                    2'd2:    mask_o[r]       <= wdata[LANES-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n) begin
            len_o <= '0;
        end else if (we && wr_row == LAST_ROW && wr_word == 2'd3 && len_ok) begin
            len_o <= wdata[LEN_W-1:0];
        end
    end

endmodule

// File: rtl/pktpat_lane_cmp.sv
module pktpat_lane_cmp
    import pktpat_pkg::*;
(
    input  logic [LANES*8-1:0] pat,
    input  logic [LANES-1:0]   en,
    input  logic [LANES*8-1:0] data,
    output logic               mism
);

    logic [LANES-1:0] lane_bad;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_bad[i] = en[i] && (data[8*i +: 8] != pat[8*i +: 8]);
    end

    assign mism = |lane_bad;

endmodule

// File: rtl/pktpat_ctrl.sv
module pktpat_ctrl
    import pktpat_pkg::*;
#(
    parameter int ROWS    = 16,
    parameter int MAX_LEN = 128,
    parameter int LEN_W   = 8,
    parameter int ROW_W   = 4,
    parameter int GRP_W   = 5
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              s_valid,
    input  logic [LANES-1:0]  s_keep,
    input  logic              s_last,
    input  logic              beat_mism,
    input  logic [LEN_W-1:0]  len_i,
    output logic [ROW_W-1:0]  grp_o,
    output logic              res_valid,
    output logic              res_pass
);

    flt_state_e        state_q, state_d;
    logic [GRP_W-1:0]  beat_q;
    logic [LEN_W-1:0]  cnt_q;
    logic              bad_q;

    logic              pkt_rst;
    logic [LEN_W:0]    len_up;
    logic [LEN_W:0]    ngroups;
    logic [GRP_W-1:0]  grp_cur;
    logic [LEN_W:0]    grp_cur_w;
    logic [LEN_W:0]    grp_nxt;
    logic              in_win;
    logic              beat_bad;
    logic              bad_nx;
    logic [LEN_W-1:0]  cnt_base;
    logic [LEN_W:0]    cnt_sum;
    logic [LEN_W-1:0]  cnt_nx;
    logic              len_met;
    logic              end_beat;

    assign pkt_rst = !por_n || !rst_n;

    // Window geometry: number of 8-byte groups that hold window bytes.
    assign len_up  = {1'b0, len_i} + (LEN_W+1)'(LANES - 1);
    assign ngroups = len_up >> 3;

    assign grp_cur   = (state_q == ST_IDLE) ? '0 : beat_q;
    assign grp_cur_w = (LEN_W+1)'(grp_cur);
    assign grp_nxt   = grp_cur_w + 1'b1;
    assign grp_o     = grp_cur[ROW_W-1:0];

    assign in_win   = (state_q != ST_TAIL) && (grp_cur_w < ngroups);
    assign beat_bad = in_win && beat_mism;
    assign bad_nx   = ((state_q == ST_IDLE) ? 1'b0 : bad_q) || beat_bad;

    // Saturating byte count; saturation at MAX_LEN keeps the length test exact.
    assign cnt_base = (state_q == ST_IDLE) ? '0 : cnt_q;
    assign cnt_sum  = {1'b0, cnt_base} + (LEN_W+1)'(lane_count(s_keep));
    assign cnt_nx   = (cnt_sum > (LEN_W+1)'(MAX_LEN)) ? LEN_W'(MAX_LEN)
                                                      : cnt_sum[LEN_W-1:0];
    assign len_met  = (cnt_nx >= len_i);
    assign end_beat = s_valid && s_last;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (s_valid && !s_last) begin
                    state_d = (grp_nxt < ngroups) ? ST_CMP : ST_TAIL;
                end
            end
            ST_CMP: begin
                if (s_valid) begin
                    if (s_last) begin
                        state_d = ST_IDLE;
                    end else if (grp_nxt >= ngroups) begin
                        state_d = ST_TAIL;
                    end
                end
            end
            ST_TAIL: begin
                if (end_beat) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (pkt_rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Per-packet tracking.
    always_ff @(posedge clk) begin
        if (pkt_rst) begin
            beat_q <= '0;
            cnt_q  <= '0;
            bad_q  <= 1'b0;
        end else if (s_valid) begin
            cnt_q <= cnt_nx;
            bad_q <= bad_nx;
            if (state_d == ST_CMP) begin
                beat_q <= GRP_W'(grp_nxt);
            end
        end
    end

    // Verdict outputs.
    always_ff @(posedge clk) begin
        if (pkt_rst) begin
            res_valid <= 1'b0;
            res_pass  <= 1'b0;
        end else begin
            res_valid <= end_beat;
            res_pass  <= end_beat && !bad_nx && len_met;
        end
    end

endmodule

// File: rtl/pktpat_filter.sv
module pktpat_filter
    import pktpat_pkg::*;
#(
    parameter int PAT_BYTES = 128
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         rst_n,
    input  logic         s_valid,
    input  logic [63:0]  s_data,
    input  logic [7:0]   s_keep,
    input  logic         s_last,
    input  logic         cfg_we,
    input  logic [5:0]   cfg_addr,
    input  logic [31:0]  cfg_wdata,
    output logic         res_valid,
    output logic         res_pass
);

    localparam int ROWS   = PAT_BYTES / LANES;
    localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int GRP_W  = $clog2(ROWS + 1);
    localparam int LEN_W  = $clog2(PAT_BYTES + 1);
    localparam int CFG_AW = ROW_W + 2;

    logic [ROWS-1:0][LANES*8-1:0] pat_all;
    logic [ROWS-1:0][LANES-1:0]   en_all;
    logic [LEN_W-1:0]             cfg_len;
    logic [ROW_W-1:0]             grp_sel;
    logic [LANES*8-1:0]           row_pat;
    logic [LANES-1:0]             row_en;
    logic                         beat_mism;

    pktpat_cfg_store #(
        .ROWS    (ROWS),
        .MAX_LEN (PAT_BYTES),
        .LEN_W   (LEN_W),
        .CFG_AW  (CFG_AW)
    ) u_cfg (
        .clk    (clk),
        .por_n  (por_n),
        .we     (cfg_we),
        .addr   (cfg_addr[CFG_AW-1:0]),
        .wdata  (cfg_wdata),
        .pat_o  (pat_all),
        .mask_o (en_all),
        .len_o  (cfg_len)
    );

    assign row_pat = pat_all[grp_sel];
    assign row_en  = en_all[grp_sel];

    pktpat_lane_cmp u_cmp (
        .pat  (row_pat),
        .en   (row_en),
        .data (s_data),
        .mism (beat_mism)
    );

    pktpat_ctrl #(
        .ROWS    (ROWS),
        .MAX_LEN (PAT_BYTES),
        .LEN_W   (LEN_W),
        .ROW_W   (ROW_W),
        .GRP_W   (GRP_W)
    ) u_ctrl (
        .clk       (clk),
        .por_n     (por_n),
        .rst_n     (rst_n),
        .s_valid   (s_valid),
        .s_keep    (s_keep),
        .s_last    (s_last),
        .beat_mism (beat_mism),
        .len_i     (cfg_len),
        .grp_o     (grp_sel),
        .res_valid (res_valid),
        .res_pass  (res_pass)
    );

endmodule

// File: rtl/pktpat_filter_chk.sv
module pktpat_filter_chk
    import pktpat_pkg::*;
#(
    parameter int MAX_LEN = 128,
    parameter int LEN_W   = 8
) (
    input logic              clk,
    input logic              por_n,
    input logic              rst_n,
    input logic              s_valid,
    input logic [LANES-1:0]  s_keep,
    input logic              s_last,
    input logic              cfg_we,
    input logic [LEN_W-1:0]  cfg_len,
    input logic              res_valid,
    input logic              res_pass
);

    logic armed_q;
    logic in_pkt_q;
    int   cnt_q;
    logic short_q;
    logic len0_q;
    int   tot;

    always_comb begin
        tot = (in_pkt_q ? cnt_q : 0) + int'(lane_count(s_keep));
        if (tot > 4096) tot = 4096;
    end

    always_ff @(posedge clk) begin
        if (!por_n || !rst_n) begin
            armed_q  <= 1'b0;
            in_pkt_q <= 1'b0;
            cnt_q    <= 0;
            short_q  <= 1'b0;
            len0_q   <= 1'b0;
        end else begin
            armed_q <= 1'b1;
            if (s_valid) begin
                if (s_last) begin
                    in_pkt_q <= 1'b0;
                    cnt_q    <= 0;
                    short_q  <= (tot < int'(cfg_len));
                    len0_q   <= (cfg_len == '0);
                end else begin
                    in_pkt_q <= 1'b1;
                    cnt_q    <= tot;
                end
            end
        end
    end

    p_verdict_pulse_r7: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        armed_q |-> (res_valid == $past(s_valid && s_last)));

    p_short_fails_r4: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (res_valid && short_q) |-> !res_pass);

    p_zero_len_pass_r5: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
        (res_valid && len0_q) |-> res_pass);

    p_len_limit_r10: assert property (@(posedge clk) disable iff (!por_n)
        int'(cfg_len) <= MAX_LEN);

    p_len_hold_r9: assert property (@(posedge clk) disable iff (!por_n)
        !cfg_we |=> $stable(cfg_len));

endmodule

bind pktpat_filter pktpat_filter_chk #(
    .MAX_LEN (PAT_BYTES),
    .LEN_W   (LEN_W)
) u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .rst_n     (rst_n),
    .s_valid   (s_valid),
    .s_keep    (s_keep),
    .s_last    (s_last),
    .cfg_we    (cfg_we),
    .cfg_len   (cfg_len),
    .res_valid (res_valid),
    .res_pass  (res_pass)
);

// File: tb/pktpat_filter_bench.sv
`timescale 1ns/1ps
module pktpat_filter_bench;

    localparam int PB   = 128;
    localparam int ROWS = PB / 8;
    localparam int BUSN = 176;

    logic        clk = 1'b0;
    logic        por_n, rst_n;
    logic        s_valid, s_last, cfg_we;
    logic [63:0] s_data;
    logic [7:0]  s_keep;
    logic [5:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic        res_valid, res_pass;

    always #2 clk = ~clk;

    pktpat_filter u_pktpat_filter (
        .clk(clk), .por_n(por_n), .rst_n(rst_n),
        .s_valid(s_valid), .s_data(s_data), .s_keep(s_keep), .s_last(s_last),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .res_valid(res_valid), .res_pass(res_pass)
    );

    int checks = 0;
    int errors = 0;

    logic [7:0] pat_m [PB];
    bit         en_m  [PB];
    int         len_m;
    logic [7:0] bus   [BUSN];

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        report();
    end

    // Reference verdict from the requirements.
    function automatic int model(int n);
        int g;
        if (n < len_m) return 0;
        g = (len_m + 7) / 8;
        for (int b = 0; b < g * 8; b++) begin
            if (en_m[b] && bus[b] != pat_m[b]) return 0;
        end
        return 1;
    endfunction

    task automatic cfg_wr(int addr, logic [31:0] d);
        cfg_we    = 1'b1;
        cfg_addr  = 6'(addr);
        cfg_wdata = d;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic load_row(int r);
        logic [31:0] w0, w1, w2;
        for (int i = 0; i < 4; i++) begin
            w0[8*i +: 8] = pat_m[8*r + i];
            w1[8*i +: 8] = pat_m[8*r + 4 + i];
        end
        w2 = '0;
        for (int i = 0; i < 8; i++) w2[i] = en_m[8*r + i];
        cfg_wr(4*r + 0, w0);
        cfg_wr(4*r + 1, w1);
        cfg_wr(4*r + 2, w2);
    endtask

    task automatic set_len(int v);
        if (v <= PB) len_m = v;
        cfg_wr(4*(ROWS-1) + 3, 32'(v));
    endtask

    task automatic load_all();
        for (int r = 0; r < ROWS; r++) load_row(r);
        set_len(len_m);
    endtask

    task automatic make_bus();
        for (int b = 0; b < BUSN; b++) begin
            if (b < PB && en_m[b]) bus[b] = pat_m[b];
            else                   bus[b] = 8'($urandom);
        end
    endtask

    task automatic idle(int n);
        s_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Drive one packet from bus[], checking the verdict one cycle after the last beat.
    task automatic send_pkt(int n, int gap_pct, string req);
        int beats, expv, rem;
        beats = (n + 7) / 8;
        expv  = model(n);
        rem   = n % 8;
        for (int bt = 0; bt < beats; bt++) begin
            if (bt > 0 && int'($urandom % 100) < gap_pct) begin
                s_valid = 1'b0;
                s_last  = 1'($urandom);
                s_keep  = 8'($urandom);
                s_data  = {$urandom, $urandom};
                @(negedge clk);
                check("R12", "strobe during gap", int'(res_valid), 0);
            end
            s_valid = 1'b1;
            for (int i = 0; i < 8; i++) s_data[8*i +: 8] = bus[8*bt + i];
            s_last = (bt == beats - 1);
            if (bt == beats - 1 && rem != 0) s_keep = 8'((1 << rem) - 1);
            else                             s_keep = 8'hFF;
            @(negedge clk);
            if (bt == beats - 1) begin
                check("R7", "strobe after last beat", int'(res_valid), 1);
                check(req, $sformatf("verdict n=%0d len=%0d", n, len_m), int'(res_pass), expv);
            end else begin
                check("R7", "strobe mid packet", int'(res_valid), 0);
            end
        end
        s_valid = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        por_n = 1'b0; rst_n = 1'b0;
        s_valid = 1'b0; s_last = 1'b0; s_keep = '0; s_data = '0;
        cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        for (int b = 0; b < PB; b++) begin pat_m[b] = '0; en_m[b] = 1'b0; end
        len_m = 0;
        repeat (3) @(negedge clk);
        check("R1", "res_valid in reset", int'(res_valid), 0);
        check("R1", "res_pass in reset", int'(res_pass), 0);
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);

        // R1: cleared configuration passes any packet.
        make_bus();
        send_pkt(20, 0, "R1");
        idle(1);

        // Deterministic configuration.
        for (int b = 0; b < PB; b++) begin pat_m[b] = 8'(b * 7 + 3); en_m[b] = 1'b1; end
        len_m = 16;
        load_all();

        // R11: lane order.
        make_bus(); send_pkt(16, 0, "R11"); idle(1);
        make_bus();
        begin logic [7:0] t; t = bus[0]; bus[0] = bus[7]; bus[7] = t; end
        send_pkt(16, 0, "R11"); idle(1);

        // R3: single enabled mismatch.
        make_bus(); bus[9] ^= 8'h5A; send_pkt(16, 0, "R3"); idle(1);

        // R2: disabled byte ignored.
        en_m[5] = 1'b0; load_row(0);
        make_bus(); bus[5] ^= 8'h5A; send_pkt(16, 0, "R2"); idle(1);

        // R4 / R5: length boundary.
        make_bus(); send_pkt(15, 0, "R4"); idle(1);
        make_bus(); send_pkt(16, 0, "R5"); idle(1);

        // R6: unaligned window compares whole group, including absent lanes.
        set_len(10);
        make_bus(); send_pkt(10, 0, "R6"); idle(1);
        make_bus(); bus[12] ^= 8'h5A; send_pkt(10, 0, "R6"); idle(1);
        // R5: bytes after the compared groups are ignored.
        make_bus(); bus[17] ^= 8'h5A; send_pkt(24, 0, "R5"); idle(1);

        // R10: ignored writes.
        set_len(200);
        make_bus(); send_pkt(12, 0, "R10"); idle(1);
        cfg_wr(2, 32'hFFFF_FF00);
        for (int i = 0; i < 8; i++) en_m[i] = 1'b0;
        make_bus(); bus[3] ^= 8'h5A; send_pkt(12, 0, "R10"); idle(1);
        cfg_wr(3, 32'h0000_0004);
        make_bus(); send_pkt(8, 0, "R10"); idle(1);

        // R8: back-to-back packets.
        set_len(16);
        make_bus(); bus[9] ^= 8'h5A; send_pkt(16, 0, "R8");
        make_bus(); send_pkt(16, 0, "R8");
        set_len(8);
        for (int i = 0; i < 8; i++) en_m[i] = 1'b1;
        load_row(0);
        make_bus(); send_pkt(8, 0, "R8");
        make_bus(); bus[2] ^= 8'h5A; send_pkt(8, 0, "R8");
        make_bus(); send_pkt(8, 0, "R8");
        idle(1);

        // R12: idle gaps inside packets.
        set_len(40);
        make_bus(); send_pkt(40, 60, "R12"); idle(1);
        make_bus(); bus[33] ^= 8'h5A; send_pkt(48, 60, "R12"); idle(1);

        // R9: soft reset mid packet keeps configuration.
        set_len(16);
        make_bus(); bus[0] ^= 8'h5A;
        s_valid = 1'b1; s_last = 1'b0; s_keep = 8'hFF;
        for (int i = 0; i < 8; i++) s_data[8*i +: 8] = bus[i];
        @(negedge clk);
        s_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        check("R9", "res_valid in soft reset", int'(res_valid), 0);
        rst_n = 1'b1;
        make_bus(); send_pkt(16, 0, "R9"); idle(1);

        // Full-size window.
        set_len(128);
        make_bus(); send_pkt(128, 0, "R5"); idle(1);
        make_bus(); bus[140] ^= 8'h5A; send_pkt(160, 20, "R5"); idle(1);
        make_bus(); send_pkt(127, 0, "R4"); idle(1);
        make_bus(); bus[120] ^= 8'h5A; send_pkt(128, 0, "R3"); idle(1);

        // Constrained random traffic.
        for (int k = 0; k < 300; k++) begin
            int n;
            if (k % 50 == 0) begin
                for (int b = 0; b < PB; b++) begin
                    pat_m[b] = 8'($urandom);
                    en_m[b]  = ($urandom % 4) != 0;
                end
                len_m = int'($urandom % (PB + 1));
                load_all();
            end
            n = 1 + int'($urandom % 160);
            if (k % 4 == 0) begin
                n = len_m - 1 + int'($urandom % 3);
                if (n < 1) n = 1;
            end
            make_bus();
            if ($urandom % 3 == 0) begin
                int idx;
                idx = int'($urandom % (((n + 7) / 8) * 8));
                bus[idx] ^= 8'h5A;
            end
            send_pkt(n, (k % 2 == 1) ? 30 : 0, "R3");
            if ($urandom % 2 == 1) idle(1);
        end

        idle(2);
        report();
    end

endmodule